// File: doc/BRIEF.md
# Pin Change Interrupt Detector

This block watches a small group of asynchronous general-purpose input pins and raises one shared, sticky flag whenever a pin that is selected by its per-pin mask bit changes level. Every pin passes through a chain of rising-edge flip-flops. A change is found by comparing the two oldest samples of that chain. No stage is transparent on a clock level, so a runt pulse just before a real edge can never hide that edge. If the level after a burst of glitches differs from the level before it, the change always reaches the flag.

The flag is held by a two-state machine. The state `FLAG_QUIET` moves to `FLAG_PENDING` on the *arm* transition, which is any change on a masked-in pin. `FLAG_PENDING` goes back to `FLAG_QUIET` on the *clear* transition, which is the clear strobe in a cycle with no change. In every other case each state *holds*. The interrupt request is the flag qualified by a group enable bit.

While the system clock is stopped, a combinational wake path compares each raw masked-in pin against its last synchronized level. It asserts a wake request on the first edge, without waiting for any clock.

Top module: `pin_change_detector`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), flag, irq and wake_req are 0. The synchronizer loads the current pin levels, so no change is reported after release, even when pins are non-zero.
- R2: A level held for at least one clock period on a pin whose mask bit is 1 sets flag within three rising edges of the change.
- R3: A change on a pin whose mask bit is 0 leaves flag unchanged.
- R4: irq is 1 exactly when flag is 1 and group_en is 1. flag still records changes while group_en is 0.
- R5: flag is sticky. A one-cycle flag_clr with no change in that cycle returns flag to 0 on the next edge.
- R6: When flag_clr and a detected change fall in the same cycle, the change wins and flag stays 1.
- R7: The sequence runt pulse, then immediate final edge (in both directions, at each quarter-period phase offset) produces exactly one rising edge of flag per net level change.
- R8: A stand-alone pulse of half a clock period that spans a rising edge sets flag. A separate normal edge several clocks later sets flag again on its own.
- R9: With clk_halted at 1, a level change on a masked-in pin raises wake_req at once, with no clock edge. wake_req is 0 whenever clk_halted is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_raw | input | NPINS | Asynchronous pin levels |
| pin_mask | input | NPINS | Per-pin select, 1 = pin takes part |
| group_en | input | 1 | Enables the shared interrupt request |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| clk_halted | input | 1 | 1 while the system clock is stopped |
| flag | output | 1 | Sticky change flag |
| irq | output | 1 | Interrupt request, flag gated by group_en |
| wake_req | output | 1 | Asynchronous wake request |

## Verification
The assertions assume three things about the inputs:
- pin_mask, group_en and flag_clr are synchronous to clk;
- flag_clr is a single-cycle strobe;
- clk_halted is raised only while the clock is actually stopped.

The stimulus changes these controls only at falling edges. Pin levels move at arbitrary sub-cycle offsets, including runt pulses at four phases. The clock is gated off before clk_halted is set and restarted only after clk_halted drops, so the wake property is never exercised with a running clock.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
    typedef enum logic {
        FLAG_QUIET   = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_t;
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
    parameter int NPINS       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_raw,
    output logic [NPINS-1:0] smp_new,
    output logic [NPINS-1:0] smp_old
);
    localparam int CHAIN = SYNC_STAGES + 1;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [CHAIN-1:0] chain;
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain <= {CHAIN{pin_raw[i]}};
            else
                chain <= {chain[CHAIN-2:0], pin_raw[i]};
        end
        assign smp_new[i] = chain[CHAIN-2];
        assign smp_old[i] = chain[CHAIN-1];
    end
endmodule

// File: rtl/pcd_change.sv
module pcd_change #(
    parameter int NPINS = 6
) (
    input  logic [NPINS-1:0] smp_new,
    input  logic [NPINS-1:0] smp_old,
    input  logic [NPINS-1:0] pin_mask,
    output logic             any_change
);
    logic [NPINS-1:0] diff;
    always_comb begin
        diff       = (smp_new ^ smp_old) & pin_mask;
        any_change = |diff;
    end
endmodule

// File: rtl/pcd_flag_fsm.sv
module pcd_flag_fsm
    import pcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_change,
    input  logic flag_clr,
    input  logic group_en,
    output logic flag,
    output logic irq
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_QUIET:   if (any_change)             state_d = FLAG_PENDING;
            FLAG_PENDING: if (flag_clr && !any_change) state_d = FLAG_QUIET;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_PENDING);
        irq  = flag & group_en;
    end
endmodule

// File: rtl/pcd_wake.sv
module pcd_wake #(
    parameter int NPINS = 6
) (
    input  logic             rst_n,
    input  logic             clk_halted,
    input  logic [NPINS-1:0] pin_raw,
    input  logic [NPINS-1:0] ref_lvl,
    input  logic [NPINS-1:0] pin_mask,
    output logic             wake_req
);
    always_comb
        wake_req = rst_n & clk_halted & (|((pin_raw ^ ref_lvl) & pin_mask));
endmodule

// File: rtl/pin_change_detector.sv
module pin_change_detector #(
    parameter int NPINS       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_raw,
    input  logic [NPINS-1:0] pin_mask,
    input  logic             group_en,
    input  logic             flag_clr,
    input  logic             clk_halted,
    output logic             flag,
    output logic             irq,
    output logic             wake_req
);
    logic [NPINS-1:0] smp_new, smp_old;
    logic             any_change;

    pcd_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
        .smp_new(smp_new), .smp_old(smp_old)
    );

    pcd_change #(.NPINS(NPINS)) u_change (
        .smp_new(smp_new), .smp_old(smp_old), .pin_mask(pin_mask),
        .any_change(any_change)
    );

    pcd_flag_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .any_change(any_change),
        .flag_clr(flag_clr), .group_en(group_en),
        .flag(flag), .irq(irq)
    );

    pcd_wake #(.NPINS(NPINS)) u_wake (
        .rst_n(rst_n), .clk_halted(clk_halted), .pin_raw(pin_raw),
        .ref_lvl(smp_old), .pin_mask(pin_mask), .wake_req(wake_req)
    );
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
    parameter int NPINS = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pin_mask,
    input logic             group_en,
    input logic             flag_clr,
    input logic             clk_halted,
    input logic             any_change,
    input logic             flag,
    input logic             irq,
    input logic             wake_req
);
    assert_change_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any_change |=> flag);

    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mask == '0 && !flag) |=> !flag);

    assert_irq_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> group_en);

    assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> !irq);

    assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && flag_clr && !any_change) |=> !flag);

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !any_change) |=> !flag);

    assert_change_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && any_change) |=> flag);

    always_comb begin
        if (rst_n && !clk_halted)
            assert_wake_gated_R9: assert (!wake_req);
    end
endmodule

bind pin_change_detector pcd_checker #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_mask(pin_mask), .group_en(group_en),
    .flag_clr(flag_clr), .clk_halted(clk_halted), .any_change(any_change),
    .flag(flag), .irq(irq), .wake_req(wake_req)
);

// File: tb/pin_change_detector_test.sv
`timescale 1ns/100ps
module pin_change_detector_test;
    localparam int NPINS = 6;

    logic clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
    logic [NPINS-1:0] pin_raw = 6'b101010, pin_mask = '0;
    logic group_en = 1'b0, flag_clr = 1'b0, clk_halted = 1'b0;
    logic flag, irq, wake_req;
    int total = 0, bad = 0, rise_cnt = 0;
    bit finished = 0;

    always #2 if (clk_run) clk = ~clk;

    pin_change_detector #(.NPINS(NPINS), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .pin_mask(pin_mask),
        .group_en(group_en), .flag_clr(flag_clr), .clk_halted(clk_halted),
        .flag(flag), .irq(irq), .wake_req(wake_req)
    );

    always @(posedge flag) rise_cnt++;

    // entry: [14:9] mask, [8:3] pins, [2] group_en, [1] expected flag, [0] expected irq
    localparam int NVEC = 6;
    localparam logic [14:0] VEC [NVEC] = '{
        {6'b111111, 6'b000001, 1'b1, 1'b1, 1'b1},
        {6'b111110, 6'b000000, 1'b1, 1'b0, 1'b0},
        {6'b000100, 6'b000100, 1'b0, 1'b1, 1'b0},
        {6'b000100, 6'b001000, 1'b1, 1'b1, 1'b1},
        {6'b110000, 6'b001011, 1'b1, 1'b0, 1'b0},
        {6'b100000, 6'b101011, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_clear(input string req);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(req, flag, 0);
    endtask

    task automatic runt_edge(input int bitn, input logic newv, input int q);
        @(negedge clk);
        rise_cnt = 0;
        @(posedge clk);
        #(0.5 + q);
        pin_raw[bitn] = newv;
        #2 pin_raw[bitn] = ~newv;
        #2 pin_raw[bitn] = newv;
        wait_cyc(6);
        chk($sformatf("R7 flag q=%0d dir=%0d", q, newv), flag, 1);
        chk($sformatf("R7 single rise q=%0d dir=%0d", q, newv), rise_cnt, 1);
        do_clear("R5 clear after runt");
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        finish_up();
    end

    initial begin
        // R1: reset with non-zero pins
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        pin_mask = '1;
        group_en = 1'b1;
        wait_cyc(5);
        chk("R1 flag after reset", flag, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R1 wake after reset", wake_req, 0);

        // R3: pins move with every mask bit at 0
        pin_mask = '0;
        pin_raw  = '0;
        wait_cyc(5);
        chk("R3 all masked", flag, 0);

        // Table walk: R2, R3, R4
        for (int i = 0; i < NVEC; i++) begin
            pin_mask = VEC[i][14:9];
            group_en = VEC[i][2];
            pin_raw  = VEC[i][8:3];
            wait_cyc(4);
            chk($sformatf("R2/R3 flag vec %0d", i), flag, int'(VEC[i][1]));
            chk($sformatf("R4 irq vec %0d", i), irq, int'(VEC[i][0]));
            do_clear($sformatf("R5 clear vec %0d", i));
        end

        // R6: clear and change in the same cycle (flag already set)
        pin_mask = '1;
        group_en = 1'b1;
        pin_raw[3] = ~pin_raw[3];
        wait_cyc(4);
        chk("R6 precondition", flag, 1);
        pin_raw[3] = ~pin_raw[3];      // change visible in the cycle after the second edge
        wait_cyc(2);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R6 change beats clear", flag, 1);
        wait_cyc(1);
        chk("R5 sticky hold", flag, 1);
        do_clear("R5 clear after R6");

        // R7: runt then edge, every quarter phase, both directions
        for (int q = 0; q < 4; q++) begin
            runt_edge(2, 1'b1, q);
            runt_edge(2, 1'b0, q);
        end

        // R8: stand-alone half-period pulse spanning an edge, then a separate edge
        @(posedge clk);
        #3 pin_raw[1] = ~pin_raw[1];
        #2 pin_raw[1] = ~pin_raw[1];
        wait_cyc(6);
        chk("R8 lone pulse", flag, 1);
        do_clear("R5 clear after pulse");
        wait_cyc(5);
        pin_raw[1] = ~pin_raw[1];
        wait_cyc(4);
        chk("R8 later edge", flag, 1);
        do_clear("R5 clear after edge");

        // R9: wake with the clock stopped
        clk_run = 1'b0;
        #1 clk_halted = 1'b1;
        #2 chk("R9 wake idle", wake_req, 0);
        pin_raw[4] = ~pin_raw[4];
        #1 chk("R9 wake on edge", wake_req, 1);
        clk_halted = 1'b0;
        #1 chk("R9 wake gated", wake_req, 0);
        clk_run = 1'b1;
        wait_cyc(4);
        chk("R2 change after restart", flag, 1);
        do_clear("R5 final clear");

        finish_up();
    end
endmodule